// File: doc/BRIEF.md
# Valid-Ready Handshake Rule Monitor

This block observes one point-to-point streaming channel in which a source raises a valid strobe, a sink raises a ready strobe, and a word moves in every cycle where both strobes are high. The block drives nothing back onto the channel. It only watches the channel and raises one sticky error flag for each handshake rule that is broken, plus a combined error output.

Four rules are checked. The source may lower valid only right after a completed transfer. The sink may lower ready only right after a completed transfer. The data word must not change in the cycle after a stall, where a stall is a cycle with valid high and ready low. A run of consecutive stalls must not reach a configurable limit. The stall rule makes a bounded-progress goal into a plain safety check through a saturating counter. The monitor can sit next to any channel, in silicon or in simulation, and its flags can be routed to a debug or interrupt path.

The edge and hold rules compare the current cycle with registered copies of the previous cycle. These rules are suppressed in the first cycle after reset, when no previous cycle has been recorded.

Top module: `hs_channel_monitor`

## Requirements
- R1: While `rst` is high at a rising clock edge, all four flags and `err_any` read 0 after that edge.
- R2: If `src_valid` was 1 and `snk_ready` was 0 in cycle n-1, and `src_valid` is 0 in cycle n, then `err_valid_drop` reads 1 after the edge that ends cycle n.
- R3: If both strobes were 1 in cycle n-1, lowering `src_valid` in cycle n does not set `err_valid_drop`.
- R4: If `snk_ready` was 1 and `src_valid` was 0 in cycle n-1, and `snk_ready` is 0 in cycle n, then `err_ready_drop` reads 1 after the edge that ends cycle n.
- R5: If both strobes were 1 in cycle n-1, lowering `snk_ready` in cycle n does not set `err_ready_drop`.
- R6: If cycle n-1 was a stall and `data` in cycle n differs from `data` in cycle n-1, then `err_data_hold` reads 1 after the edge that ends cycle n. A change in `data` after any cycle that was not a stall has no effect.
- R7: A stall counter counts consecutive stall cycles, clears on any cycle that is not a stall, and saturates at `STALL_LIMIT`. After `STALL_LIMIT` consecutive stall cycles, `err_stall_timeout` reads 1 after the next edge. A run of `STALL_LIMIT`-1 stall cycles followed by a transfer never sets it.
- R8: Once set, each flag stays set on every edge until reset, whatever the channel does.
- R9: `err_any` is 1 exactly when at least one of the four flags is 1.
- R10: In the first cycle after reset is released, the edge and hold rules cannot fire, whatever the strobes did during reset.
- R11: While `rst` stays high, a sequence of cycles that would otherwise break the rules raises no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| src_valid | input | 1 | Valid strobe from the source |
| snk_ready | input | 1 | Ready strobe from the sink |
| data | input | DATA_W | Channel data word |
| err_valid_drop | output | 1 | Sticky: valid lowered without a completed transfer |
| err_ready_drop | output | 1 | Sticky: ready lowered without a completed transfer |
| err_data_hold | output | 1 | Sticky: data changed after a stall cycle |
| err_stall_timeout | output | 1 | Sticky: stall run reached STALL_LIMIT |
| err_any | output | 1 | OR of the four sticky flags |

## Verification
The bench builds the monitor with `DATA_W` = 16 and `STALL_LIMIT` = 8. With the default limit of 1000, reaching the timeout would take about a thousand cycles for each attempt. With a limit of 8, the bench can test both edges of R7 directly: a run of exactly limit-1 stall cycles, a run of exactly limit, and saturation after the limit. Random stretches also reach the timeout often. A data width of 16 keeps random hold violations frequent, and each word is still wide enough that a changed word is rarely equal to the old one by chance.

// File: rtl/hsm_pkg.sv
package hsm_pkg;

  typedef enum int unsigned {
    RULE_VALID = 0,
    RULE_READY = 1,
    RULE_HOLD  = 2,
    RULE_STALL = 3
  } rule_e;

  localparam int unsigned NUM_RULES = 4;

  // A strobe lowered in this cycle, while the previous cycle was not a transfer.
  function automatic logic early_drop(input logic prev_self, input logic prev_other,
                                      input logic cur_self);
    return prev_self && !cur_self && !prev_other;
  endfunction

  // The word moved while the previous cycle stalled.
  function automatic logic hold_broken(input logic prev_vld, input logic prev_rdy,
                                       input logic words_differ);
    return prev_vld && !prev_rdy && words_differ;
  endfunction

  // Next stall count: it clears when there is no stall and saturates at the limit.
  function automatic int unsigned stall_step(input int unsigned cnt, input logic stall,
                                             input int unsigned limit);
    if (!stall)          return 0;
    else if (cnt >= limit) return limit;
    else                 return cnt + 1;
  endfunction

endpackage

// File: rtl/hsm_history.sv
module hsm_history #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cur_vld,
  input  logic              cur_rdy,
  input  logic [DATA_W-1:0] cur_dat,
  output logic              prev_vld,
  output logic              prev_rdy,
  output logic [DATA_W-1:0] prev_dat,
  output logic              hist_ok
);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_vld <= 1'b0;
      prev_rdy <= 1'b0;
      prev_dat <= '0;
      hist_ok  <= 1'b0;
    end else begin
      prev_vld <= cur_vld;
      prev_rdy <= cur_rdy;
      prev_dat <= cur_dat;
      hist_ok  <= 1'b1;
    end
  end

endmodule

// File: rtl/hsm_stall_timer.sv
module hsm_stall_timer #(
  parameter int STALL_LIMIT = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic stall,
  output logic limit_hit
);

  localparam int CNT_W = $clog2(STALL_LIMIT + 1);
  localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(STALL_LIMIT);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = CNT_W'(hsm_pkg::stall_step(32'(cnt_q), stall, 32'(STALL_LIMIT)));
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  assign limit_hit = (cnt_q >= LIMIT_V);

endmodule

// File: rtl/hsm_sticky_bank.sv
module hsm_sticky_bank #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_req,
  output logic [N-1:0] flags
);

  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)             flags[g] <= 1'b0;
      else if (set_req[g]) flags[g] <= 1'b1;
    end
  end

endmodule

// File: rtl/hs_channel_monitor.sv
module hs_channel_monitor #(
  parameter int DATA_W      = 32,
  parameter int STALL_LIMIT = 1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              src_valid,
  input  logic              snk_ready,
  input  logic [DATA_W-1:0] data,
  output logic              err_valid_drop,
  output logic              err_ready_drop,
  output logic              err_data_hold,
  output logic              err_stall_timeout,
  output logic              err_any
);

  import hsm_pkg::*;

  logic              prev_vld;
  logic              prev_rdy;
  logic [DATA_W-1:0] prev_dat;
  logic              hist_ok;

  hsm_history #(.DATA_W(DATA_W)) hist_i (
    .clk      (clk),
    .rst      (rst),
    .cur_vld  (src_valid),
    .cur_rdy  (snk_ready),
    .cur_dat  (data),
    .prev_vld (prev_vld),
    .prev_rdy (prev_rdy),
    .prev_dat (prev_dat),
    .hist_ok  (hist_ok)
  );

  // Named events, brought out for the checker
  logic stall_now;
  logic xfer_now;
  logic limit_hit;
  logic viol_valid;
  logic viol_ready;
  logic viol_hold;

  assign stall_now = src_valid && !snk_ready;
  assign xfer_now  = src_valid && snk_ready;

  assign viol_valid = hist_ok && early_drop(prev_vld, prev_rdy, src_valid);
  assign viol_ready = hist_ok && early_drop(prev_rdy, prev_vld, snk_ready);
  assign viol_hold  = hist_ok && hold_broken(prev_vld, prev_rdy, data != prev_dat);

  hsm_stall_timer #(.STALL_LIMIT(STALL_LIMIT)) timer_i (
    .clk       (clk),
    .rst       (rst),
    .stall     (stall_now),
    .limit_hit (limit_hit)
  );

  logic [NUM_RULES-1:0] set_req;
  logic [NUM_RULES-1:0] flags;

  always_comb begin
    set_req             = '0;
    set_req[RULE_VALID] = viol_valid;
    set_req[RULE_READY] = viol_ready;
    set_req[RULE_HOLD]  = viol_hold;
    set_req[RULE_STALL] = limit_hit;
  end

  hsm_sticky_bank #(.N(NUM_RULES)) flags_i (
    .clk     (clk),
    .rst     (rst),
    .set_req (set_req),
    .flags   (flags)
  );

  assign err_valid_drop    = flags[RULE_VALID];
  assign err_ready_drop    = flags[RULE_READY];
  assign err_data_hold     = flags[RULE_HOLD];
  assign err_stall_timeout = flags[RULE_STALL];
  assign err_any           = |flags;

endmodule

// File: rtl/hsm_checker.sv
module hsm_checker #(
  parameter int DATA_W      = 32,
  parameter int STALL_LIMIT = 1000
) (
  input logic              clk,
  input logic              rst,
  input logic              src_valid,
  input logic              snk_ready,
  input logic [DATA_W-1:0] data,
  input logic              err_valid_drop,
  input logic              err_ready_drop,
  input logic              err_data_hold,
  input logic              err_stall_timeout,
  input logic              err_any
);

  // The checker keeps its own count of the stall run, so that no long window has to be unrolled.
  int unsigned run_len;
  logic        seen_edge;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_len   <= 0;
      seen_edge <= 1'b0;
    end else begin
      seen_edge <= 1'b1;
      if (src_valid && !snk_ready) begin
        if (run_len < STALL_LIMIT) run_len <= run_len + 1;
      end else begin
        run_len <= 0;
      end
    end
  end

  // R2
  valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (seen_edge && $fell(src_valid) && !$past(snk_ready)) |=> err_valid_drop);

  // R3
  valid_ok_drop_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(src_valid) && $past(snk_ready) && !err_valid_drop) |=> !err_valid_drop);

  // R4
  ready_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (seen_edge && $fell(snk_ready) && !$past(src_valid)) |=> err_ready_drop);

  // R6
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (seen_edge && $past(src_valid && !snk_ready) && !$stable(data)) |=> err_data_hold);

  // R7
  stall_timeout_chk: assert property (@(posedge clk) disable iff (rst)
    (run_len >= STALL_LIMIT) |=> err_stall_timeout);

  // R8
  sticky_flags_chk: assert property (@(posedge clk) disable iff (rst)
    err_any |=> err_any);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> !err_any);

endmodule

bind hs_channel_monitor hsm_checker #(
  .DATA_W      (DATA_W),
  .STALL_LIMIT (STALL_LIMIT)
) hsm_checker_i (
  .clk               (clk),
  .rst               (rst),
  .src_valid         (src_valid),
  .snk_ready         (snk_ready),
  .data              (data),
  .err_valid_drop    (err_valid_drop),
  .err_ready_drop    (err_ready_drop),
  .err_data_hold     (err_data_hold),
  .err_stall_timeout (err_stall_timeout),
  .err_any           (err_any)
);

// File: tb/hs_channel_monitor_tb.sv
`timescale 1ns/1ps
module hs_channel_monitor_tb_top;

  localparam int DW  = 16;
  localparam int LIM = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          vld = 1'b0;
  logic          rdy = 1'b0;
  logic [DW-1:0] dat = '0;
  logic e_v, e_r, e_h, e_t, e_a;

  always #4 clk = ~clk;

  hs_channel_monitor #(.DATA_W(DW), .STALL_LIMIT(LIM)) dut_i (
    .clk (clk), .rst (rst), .src_valid (vld), .snk_ready (rdy), .data (dat),
    .err_valid_drop (e_v), .err_ready_drop (e_r), .err_data_hold (e_h),
    .err_stall_timeout (e_t), .err_any (e_a)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Reference state, built only from the requirements
  logic          m_pv = 0, m_pr = 0, m_ok = 0;
  logic [DW-1:0] m_pd = '0;
  int            m_cnt = 0;
  logic [3:0]    m_flags = '0; // {timeout, hold, ready, valid}

  function automatic logic [3:0] rule_hits(logic v, logic r, logic [DW-1:0] d);
    logic [3:0] h;
    h[0] = m_ok && m_pv && !v && !m_pr;
    h[1] = m_ok && m_pr && !r && !m_pv;
    h[2] = m_ok && m_pv && !m_pr && (d != m_pd);
    h[3] = (m_cnt >= LIM);
    return h;
  endfunction

  task automatic check_flags(string tag);
    logic [4:0] act, exp;
    act = {e_a, e_t, e_h, e_r, e_v};
    exp = {|m_flags, m_flags};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: flags {any,tmo,hold,rdy,vld} actual %b expected %b at %0t",
               tag, act, exp, $time);
    end
  endtask

  // Called at a falling edge: drive one cycle, let the edge pass, then check.
  task automatic step(logic v, logic r, logic [DW-1:0] d, string tag);
    logic [3:0] hits;
    vld = v; rdy = r; dat = d;
    hits = rule_hits(v, r, d);
    @(posedge clk);
    @(negedge clk);
    if (rst) begin
      m_flags = '0; m_cnt = 0; m_ok = 0; m_pv = 0; m_pr = 0; m_pd = '0;
    end else begin
      m_flags = m_flags | hits;
      if (v && !r) m_cnt = (m_cnt >= LIM) ? LIM : m_cnt + 1;
      else         m_cnt = 0;
      m_pv = v; m_pr = r; m_pd = d; m_ok = 1;
    end
    check_flags(tag);
  endtask

  task automatic reset_cycles(int n, string tag);
    rst = 1'b1;
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, '0, tag);
    rst = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    // R1 and R11: patterns that would break the rules while reset is held
    rst = 1'b1;
    step(1'b1, 1'b0, 16'h1111, "R1");
    step(1'b0, 1'b1, 16'h2222, "R11");
    step(1'b1, 1'b0, 16'h3333, "R11");
    step(1'b1, 1'b0, 16'h4444, "R11");
    // R10: the stall ran during reset; the first free cycle lowers valid and changes data
    rst = 1'b0;
    step(1'b0, 1'b0, 16'h5555, "R10");
    step(1'b0, 1'b0, 16'h5555, "R10");

    // R3 and R5: both strobes fall right after a transfer
    step(1'b1, 1'b1, 16'h0A0A, "R3");
    step(1'b0, 1'b0, 16'h0B0B, "R3");
    step(1'b1, 1'b1, 16'h0C0C, "R5");
    step(1'b1, 1'b0, 16'h0C0C, "R5");
    step(1'b1, 1'b1, 16'h0C0C, "R5");
    step(1'b0, 1'b0, 16'h0D0D, "R5");
    // R6 (ignored case): data changes after a cycle that was not a stall
    step(1'b0, 1'b0, 16'h1234, "R6");
    step(1'b1, 1'b1, 16'h4321, "R6");
    step(1'b1, 1'b0, 16'h9999, "R6");
    step(1'b1, 1'b1, 16'h9999, "R6");
    step(1'b0, 1'b0, 16'h0000, "R6");

    // R2: valid falls after a stall, then R8 and R9 on the flag
    step(1'b1, 1'b0, 16'h00AA, "R2");
    step(1'b0, 1'b0, 16'h00AA, "R2");
    step(1'b1, 1'b1, 16'h00BB, "R8");
    step(1'b0, 1'b0, 16'h00CC, "R9");
    reset_cycles(2, "R1");

    // R4: ready falls with no valid
    step(1'b0, 1'b1, 16'h0001, "R4");
    step(1'b0, 1'b0, 16'h0001, "R4");
    step(1'b0, 1'b0, 16'h0001, "R8");
    reset_cycles(1, "R1");

    // R6: data changes after a stall
    step(1'b1, 1'b0, 16'hF00D, "R6");
    step(1'b1, 1'b1, 16'hBEEF, "R6");
    step(1'b0, 1'b0, 16'hBEEF, "R8");
    reset_cycles(1, "R1");

    // R7: LIM-1 stalls then a transfer never times out
    for (int i = 0; i < LIM-1; i++) step(1'b1, 1'b0, 16'h7777, "R7");
    step(1'b1, 1'b1, 16'h7777, "R7");
    step(1'b0, 1'b0, 16'h7777, "R7");
    // R7: LIM stalls do time out, and the count saturates past the limit
    for (int i = 0; i < LIM+3; i++) step(1'b1, 1'b0, 16'h6666, "R7");
    step(1'b1, 1'b1, 16'h6666, "R7");
    step(1'b0, 1'b0, 16'h6666, "R8");
    reset_cycles(1, "R1");

    // Constrained random traffic, mostly legal, with resets from time to time
    void'($urandom(32'd20240611));
    for (int n = 0; n < 3000; n++) begin
      logic v, r;
      logic [DW-1:0] d;
      if (n % 97 == 96) begin
        reset_cycles(1 + ($urandom % 2), "R1");
      end else begin
        if (m_pv && !m_pr && ($urandom % 16 != 0)) v = 1'b1;
        else v = ($urandom % 3 != 0);
        if (m_pr && !m_pv && ($urandom % 16 != 0)) r = 1'b1;
        else r = ($urandom % 4 == 0) ? 1'b0 : ($urandom % 2 == 1);
        if (m_pv && !m_pr && ($urandom % 20 != 0)) d = m_pd;
        else d = DW'($urandom);
        step(v, r, d, "R2/R4/R6/R7/R9 random");
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule